// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host port and an asynchronous static RAM. The host issues one read or one write at a time over a valid/ready handshake, with an address, 16 bits of data and two byte enables. The controller turns each request into a pin sequence on the memory side: address, two chip selects (one active low, one active high), write strobe, output enable and two active-low byte-lane selects. It holds every phase for a whole number of clock cycles. Each count is derived at elaboration from a nanosecond parameter and the clock period.

A write runs through four phases: address setup, write pulse, data hold and recovery. A read holds output enable low for the access time, captures the data bus, and then waits for the bus to release before it accepts the next request. An elaboration option selects 8-bit mode. In that mode the memory is addressed by bytes, the lowest host address bit travels on data pin 15, and both lane selects stay low.

Top module: `asram_cycle_ctrl`

## Requirements
- R1: Each phase length is ceil(t_ns / CLK_NS) cycles, with a minimum of 1. At the default values (10 ns clock) this gives a 1-cycle address setup from 0 ns, a 6-cycle write pulse from 55 ns, a 7-cycle read access from 70 ns and a 3-cycle bus release from 25 ns.
- R2: On a write, chip selects and lane selects become active first. After the setup phase, sram_we_n stays low for max(pulse, data setup, address-valid-to-end minus setup) cycles. Address and write data hold steady for the whole pulse. The strobe never falls in the same cycle that chip select first goes active.
- R3: After the pulse, a write keeps its data driven for the hold phase and then deselects for recovery. Recovery is padded so that the whole write lasts at least the write cycle time: 9 busy cycles at the defaults.
- R4: On a read, chip select and sram_oe_n stay active with a stable address for max(address access, output-enable access, read cycle) cycles. The data bus is sampled on the last of these cycles.
- R5: The controller never drives data pins 0..14 while sram_oe_n is low, and never has sram_we_n and sram_oe_n low together. After a read it holds output enable high for the release time before it accepts another request: 10 busy cycles per read at the defaults.
- R6: req_ready is low from the cycle after acceptance until the access ends, and is always low while chip select is active. rsp_valid is a single-cycle pulse for each read.
- R7: In 16-bit mode, sram_lb_n = ~req_be[0] (data bits 7:0) and sram_ub_n = ~req_be[1] (bits 15:8). Only the enabled lanes are driven on a write. Read data in a disabled lane returns as zero.
- R8: A request with no effective byte enable completes after one busy cycle with no chip select, strobe or lane activity, and memory contents do not change. A read of this kind returns rsp_rdata = 0 in the cycle after acceptance.
- R9: In 8-bit mode (BYTE_MODE=1), sram_addr = req_addr[HADDR_W-1:1] and data pin 15 carries req_addr[0] for the whole access. Both lane selects are low while the chip is selected. Write data uses bits 7:0 and req_be[0] alone enables the access. Read data returns in bits 7:0 with bits 15:8 zero.
- R10: While rst is high and after it: both chip selects inactive (sram_ce1_n=1, sram_ce2=0), sram_we_n, sram_oe_n, sram_lb_n and sram_ub_n high, sram_dq_oe all zero, req_ready high and rsp_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | HADDR_W (ADDR_W+BYTE_MODE) | Host address (byte address in 8-bit mode) |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low lane |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_ce1_n | output | 1 | Chip select, active low |
| sram_ce2 | output | 1 | Chip select, active high |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Low lane select, active low |
| sram_ub_n | output | 1 | High lane select, active low |
| sram_dq_out | output | 16 | Data pin drive value |
| sram_dq_oe | output | 16 | Per-pin drive enable |
| sram_dq_in | input | 16 | Data pin sampled value |

## Verification
The 16-bit instance runs a table of writes and reads over a small memory model. Full-word, low-lane-only and high-lane-only writes are mixed with reads under different enables, so a lane-select swap, a lost lane or an unmasked read lane each leaves a distinct wrong word. The memory model returns a poison value until output enable has been low for the full access time, which exposes early sampling. Directed cases count strobe width, setup cycles and busy length on both operation kinds, and send zero-enable requests. A second instance in 8-bit mode writes two neighbouring bytes that share one memory address and differ only in the pin-15 bit, so mixing the two bytes shows up on read-back.

// File: rtl/asram_pkg.sv
package asram_pkg;

    // Ceiling of a nanosecond figure over the clock period, at least one cycle.
    function automatic int ns_to_cyc(input int t_ns, input int period_ns);
        int c;
        c = (t_ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RECOV,
        ST_ACCESS,
        ST_RELEASE,
        ST_NULL
    } phase_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic we_n;
        logic oe_n;
        logic lb_n;
        logic ub_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1,
                                        oe_n: 1'b1, lb_n: 1'b1, ub_n: 1'b1};

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/asram_lane_map.sv
module asram_lane_map #(
    parameter int ADDR_W    = 20,
    parameter int BYTE_MODE = 0,
    localparam int HADDR_W  = ADDR_W + BYTE_MODE
) (
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [15:0]        host_wdata,
    input  logic [1:0]         host_be,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               lb_n,
    output logic               ub_n,
    output logic [15:0]        dq_val,
    output logic [15:0]        lane_mask,
    output logic [15:0]        apin_mask,
    output logic               any_lane
);
    generate
        if (BYTE_MODE != 0) begin : g_x8
            assign mem_addr  = host_addr[HADDR_W-1:1];
            assign lb_n      = 1'b0;
            assign ub_n      = 1'b0;
            assign dq_val    = {host_addr[0], 7'd0, host_wdata[7:0]};
            assign lane_mask = 16'h00FF;
            assign apin_mask = 16'h8000;
            assign any_lane  = host_be[0];
        end else begin : g_x16
            assign mem_addr  = host_addr;
            assign lb_n      = ~host_be[0];
            assign ub_n      = ~host_be[1];
            assign dq_val    = host_wdata;
            assign lane_mask = {{8{host_be[1]}}, {8{host_be[0]}}};
            assign apin_mask = 16'h0000;
            assign any_lane  = |host_be;
        end
    endgenerate
endmodule

// File: rtl/asram_cycle_ctrl.sv
module asram_cycle_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BYTE_MODE = 0,
    parameter int CLK_NS    = 10,
    parameter int T_AS_NS   = 0,
    parameter int T_WP_NS   = 55,
    parameter int T_DS_NS   = 35,
    parameter int T_DH_NS   = 0,
    parameter int T_WR_NS   = 0,
    parameter int T_AW_NS   = 65,
    parameter int T_WC_NS   = 70,
    parameter int T_AA_NS   = 70,
    parameter int T_OE_NS   = 35,
    parameter int T_RC_NS   = 70,
    parameter int T_OHZ_NS  = 25,
    localparam int HADDR_W  = ADDR_W + BYTE_MODE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [HADDR_W-1:0] req_addr,
    input  logic [15:0]        req_wdata,
    input  logic [1:0]         req_be,
    output logic               rsp_valid,
    output logic [15:0]        rsp_rdata,
    output logic [ADDR_W-1:0]  sram_addr,
    output logic               sram_ce1_n,
    output logic               sram_ce2,
    output logic               sram_we_n,
    output logic               sram_oe_n,
    output logic               sram_lb_n,
    output logic               sram_ub_n,
    output logic [15:0]        sram_dq_out,
    output logic [15:0]        sram_dq_oe,
    input  logic [15:0]        sram_dq_in
);
    // Phase lengths in cycles.
    localparam int C_AS    = ns_to_cyc(T_AS_NS, CLK_NS);
    localparam int C_WP    = ns_to_cyc(T_WP_NS, CLK_NS);
    localparam int C_DS    = ns_to_cyc(T_DS_NS, CLK_NS);
    localparam int C_AW    = ns_to_cyc(T_AW_NS, CLK_NS);
    localparam int C_PULSE = imax(imax(C_WP, C_DS), C_AW - C_AS);
    localparam int C_DH    = ns_to_cyc(T_DH_NS, CLK_NS);
    localparam int C_WR    = ns_to_cyc(T_WR_NS, CLK_NS);
    localparam int C_WC    = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int C_REC   = imax(C_WR, C_WC - C_AS - C_PULSE - C_DH);
    localparam int C_ACC   = imax(imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)),
                                  ns_to_cyc(T_RC_NS, CLK_NS));
    localparam int C_REL   = ns_to_cyc(T_OHZ_NS, CLK_NS);
    localparam int CNT_MAX = imax(imax(imax(C_AS, C_PULSE), imax(C_DH, C_REC)),
                                  imax(C_ACC, C_REL));
    localparam int CW      = imax(1, $clog2(CNT_MAX + 1));

    localparam logic [CW-1:0] L_AS    = CW'(C_AS - 1);
    localparam logic [CW-1:0] L_PULSE = CW'(C_PULSE - 1);
    localparam logic [CW-1:0] L_DH    = CW'(C_DH - 1);
    localparam logic [CW-1:0] L_REC   = CW'(C_REC - 1);
    localparam logic [CW-1:0] L_ACC   = CW'(C_ACC - 1);
    localparam logic [CW-1:0] L_REL   = CW'(C_REL - 1);

    phase_e  state, nxt;
    strobe_t pins, pins_nxt;
    logic [15:0] oe_q, oe_nxt;

    logic          take, ld, cnt_zero;
    logic [CW-1:0] ld_val;

    // Mapped view of the incoming request.
    logic [ADDR_W-1:0] m_addr;
    logic              m_lb_n, m_ub_n, m_any;
    logic [15:0]       m_dq, m_lane, m_apin;

    // Captured request.
    logic [ADDR_W-1:0] q_addr;
    logic              q_lb_n, q_ub_n;
    logic [15:0]       q_dq, q_lane, q_apin;

    logic              s_lb_n, s_ub_n;
    logic [15:0]       s_lane, s_apin;

    asram_lane_map #(
        .ADDR_W   (ADDR_W),
        .BYTE_MODE(BYTE_MODE)
    ) u_map (
        .host_addr (req_addr),
        .host_wdata(req_wdata),
        .host_be   (req_be),
        .mem_addr  (m_addr),
        .lb_n      (m_lb_n),
        .ub_n      (m_ub_n),
        .dq_val    (m_dq),
        .lane_mask (m_lane),
        .apin_mask (m_apin),
        .any_lane  (m_any)
    );

    asram_phase_cnt #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (ld),
        .load_val(ld_val),
        .zero    (cnt_zero)
    );

    // Phase sequencing.
    always_comb begin
        nxt    = state;
        take   = 1'b0;
        ld     = 1'b0;
        ld_val = '0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    take = 1'b1;
                    if (!m_any) begin
                        nxt = ST_NULL;
                    end else if (req_write) begin
                        nxt = ST_SETUP;  ld = 1'b1; ld_val = L_AS;
                    end else begin
                        nxt = ST_ACCESS; ld = 1'b1; ld_val = L_ACC;
                    end
                end
            end
            ST_SETUP:   if (cnt_zero) begin nxt = ST_PULSE;   ld = 1'b1; ld_val = L_PULSE; end
            ST_PULSE:   if (cnt_zero) begin nxt = ST_HOLD;    ld = 1'b1; ld_val = L_DH;    end
            ST_HOLD:    if (cnt_zero) begin nxt = ST_RECOV;   ld = 1'b1; ld_val = L_REC;   end
            ST_RECOV:   if (cnt_zero) nxt = ST_IDLE;
            ST_ACCESS:  if (cnt_zero) begin nxt = ST_RELEASE; ld = 1'b1; ld_val = L_REL;   end
            ST_RELEASE: if (cnt_zero) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Lane and pin-15 drive come from the new request on acceptance.
    assign s_lb_n = take ? m_lb_n : q_lb_n;
    assign s_ub_n = take ? m_ub_n : q_ub_n;
    assign s_lane = take ? m_lane : q_lane;
    assign s_apin = take ? m_apin : q_apin;

    // Pin levels for the phase being entered.
    always_comb begin
        pins_nxt = STROBE_IDLE;
        oe_nxt   = '0;
        unique case (nxt)
            ST_SETUP, ST_PULSE, ST_HOLD: begin
                pins_nxt.ce1_n = 1'b0;
                pins_nxt.ce2   = 1'b1;
                pins_nxt.lb_n  = s_lb_n;
                pins_nxt.ub_n  = s_ub_n;
                pins_nxt.we_n  = (nxt != ST_PULSE);
                oe_nxt         = s_apin | ((nxt == ST_SETUP) ? 16'h0000 : s_lane);
            end
            ST_ACCESS: begin
                pins_nxt.ce1_n = 1'b0;
                pins_nxt.ce2   = 1'b1;
                pins_nxt.lb_n  = s_lb_n;
                pins_nxt.ub_n  = s_ub_n;
                pins_nxt.oe_n  = 1'b0;
                oe_nxt         = s_apin;
            end
            default: begin
                pins_nxt = STROBE_IDLE;
                oe_nxt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pins      <= STROBE_IDLE;
            oe_q      <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            q_addr    <= '0;
            q_lb_n    <= 1'b1;
            q_ub_n    <= 1'b1;
            q_dq      <= '0;
            q_lane    <= '0;
            q_apin    <= '0;
        end else begin
            state     <= nxt;
            pins      <= pins_nxt;
            oe_q      <= oe_nxt;
            rsp_valid <= 1'b0;
            if (take) begin
                q_addr <= m_addr;
                q_lb_n <= m_lb_n;
                q_ub_n <= m_ub_n;
                q_dq   <= m_dq;
                q_lane <= m_lane;
                q_apin <= m_apin;
                if (!m_any && !req_write) begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= '0;
                end
            end
            if (state == ST_ACCESS && cnt_zero) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= sram_dq_in & q_lane;
            end
        end
    end

    assign req_ready   = (state == ST_IDLE);
    assign sram_addr   = q_addr;
    assign sram_ce1_n  = pins.ce1_n;
    assign sram_ce2    = pins.ce2;
    assign sram_we_n   = pins.we_n;
    assign sram_oe_n   = pins.oe_n;
    assign sram_lb_n   = pins.lb_n;
    assign sram_ub_n   = pins.ub_n;
    assign sram_dq_out = q_dq;
    assign sram_dq_oe  = oe_q;
endmodule

// File: rtl/asram_cycle_ctrl_chk.sv
module asram_cycle_ctrl_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce1_n,
    input logic              sram_ce2,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic [15:0]       sram_dq_out,
    input logic [15:0]       sram_dq_oe
);
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (sram_dq_oe[14:0] == 15'd0)); // R5

    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!sram_we_n && !sram_oe_n)); // R5

    AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        !sram_ce1_n |-> !req_ready); // R6

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R6

    AST_PULSE_HELD: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out))); // R2

    AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n || !sram_oe_n) |-> (!sram_ce1_n && sram_ce2)); // R4

    AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> $past(!sram_ce1_n)); // R2
endmodule

bind asram_cycle_ctrl asram_cycle_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .sram_addr  (sram_addr),
    .sram_ce1_n (sram_ce1_n),
    .sram_ce2   (sram_ce2),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_out(sram_dq_out),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/test_asram_cycle_ctrl.sv
module test_asram_cycle_ctrl;

    // Expected counts at a 10 ns clock, from R1/R3/R4/R5.
    localparam int EXP_SETUP = 1;   // 0 ns -> minimum one cycle
    localparam int EXP_PULSE = 6;   // ceil(55/10)
    localparam int EXP_WBUSY = 9;   // 1 + 6 + 1 hold + 1 recovery
    localparam int EXP_RLAT  = 7;   // ceil(70/10)
    localparam int EXP_RBUSY = 10;  // 7 access + 3 release

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0;       // 0 = 16-bit instance, 1 = 8-bit instance
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [20:0] req_addr  = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be    = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // 16-bit instance signals
    logic        w_ready, w_rsp, w_ce1_n, w_ce2, w_we_n, w_oe_n, w_lb_n, w_ub_n;
    logic [15:0] w_rdata, w_dq_out, w_dq_oe, w_dq_in;
    logic [19:0] w_addr;
    // 8-bit instance signals
    logic        b_ready, b_rsp, b_ce1_n, b_ce2, b_we_n, b_oe_n, b_lb_n, b_ub_n;
    logic [15:0] b_rdata, b_dq_out, b_dq_oe, b_dq_in;
    logic [19:0] b_addr;

    asram_cycle_ctrl i_asram_cycle_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid & ~sel), .req_ready(w_ready), .req_write(req_write),
        .req_addr(req_addr[19:0]), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(w_rsp), .rsp_rdata(w_rdata), .sram_addr(w_addr),
        .sram_ce1_n(w_ce1_n), .sram_ce2(w_ce2), .sram_we_n(w_we_n), .sram_oe_n(w_oe_n),
        .sram_lb_n(w_lb_n), .sram_ub_n(w_ub_n), .sram_dq_out(w_dq_out),
        .sram_dq_oe(w_dq_oe), .sram_dq_in(w_dq_in)
    );

    asram_cycle_ctrl #(.BYTE_MODE(1)) i_asram_cycle_ctrl_x8 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid & sel), .req_ready(b_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(b_rsp), .rsp_rdata(b_rdata), .sram_addr(b_addr),
        .sram_ce1_n(b_ce1_n), .sram_ce2(b_ce2), .sram_we_n(b_we_n), .sram_oe_n(b_oe_n),
        .sram_lb_n(b_lb_n), .sram_ub_n(b_ub_n), .sram_dq_out(b_dq_out),
        .sram_dq_oe(b_dq_oe), .sram_dq_in(b_dq_in)
    );

    // Memory models: data is valid only after output enable has been low 7 cycles.
    logic [15:0] mem_w [64];
    logic [7:0]  mem_b [128];
    int w_oecnt, b_oecnt;
    int fight_cnt, addr_move_cnt, x8_pin_cnt;

    assign w_dq_in = (!w_ce1_n && w_ce2 && !w_oe_n && w_oecnt >= EXP_RLAT)
                     ? mem_w[w_addr[5:0]] : 16'hBAD0;
    assign b_dq_in = (!b_ce1_n && b_ce2 && !b_oe_n && b_oecnt >= EXP_RLAT)
                     ? {8'hEE, mem_b[{b_addr[5:0], b_dq_out[15]}]} : 16'hBAD0;

    logic        w_we_prev;
    logic [19:0] w_addr_prev;

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem_w[i] <= 16'h0000;
            for (int i = 0; i < 128; i++) mem_b[i] <= 8'h00;
            w_oecnt <= 0; b_oecnt <= 0;
            fight_cnt <= 0; addr_move_cnt <= 0; x8_pin_cnt <= 0;
            w_we_prev <= 1'b1; w_addr_prev <= '0;
        end else begin
            if (!w_ce1_n && w_ce2 && !w_we_n) begin
                if (!w_lb_n) mem_w[w_addr[5:0]][7:0]  <= w_dq_out[7:0];
                if (!w_ub_n) mem_w[w_addr[5:0]][15:8] <= w_dq_out[15:8];
            end
            if (!b_ce1_n && b_ce2 && !b_we_n && !b_lb_n)
                mem_b[{b_addr[5:0], b_dq_out[15]}] <= b_dq_out[7:0];
            w_oecnt <= (!w_ce1_n && w_ce2 && !w_oe_n && w_we_n) ? w_oecnt + 1 : 0;
            b_oecnt <= (!b_ce1_n && b_ce2 && !b_oe_n && b_we_n) ? b_oecnt + 1 : 0;
            if ((!w_oe_n && |w_dq_oe[14:0]) || (!b_oe_n && |b_dq_oe[14:0]) ||
                (!w_oe_n && !w_we_n) || (!b_oe_n && !b_we_n))
                fight_cnt <= fight_cnt + 1;
            if (!w_we_n && !w_we_prev && w_addr != w_addr_prev)
                addr_move_cnt <= addr_move_cnt + 1;
            if (!b_ce1_n && (b_lb_n || b_ub_n || !b_dq_oe[15]))
                x8_pin_cnt <= x8_pin_cnt + 1;
            w_we_prev   <= w_we_n;
            w_addr_prev <= w_addr;
        end
    end

    // Views of the selected instance.
    logic        v_ready, v_rsp, v_ce1_n, v_we_n;
    logic [15:0] v_rdata;
    assign v_ready = sel ? b_ready : w_ready;
    assign v_rsp   = sel ? b_rsp   : w_rsp;
    assign v_ce1_n = sel ? b_ce1_n : w_ce1_n;
    assign v_we_n  = sel ? b_we_n  : w_we_n;
    assign v_rdata = sel ? b_rdata : w_rdata;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One host operation; counts are taken at negedges after the accepting edge.
    task automatic run_op(input bit wr, input logic [20:0] a, input logic [15:0] d,
                          input logic [1:0] be, output logic [15:0] rd,
                          output int busy, output int we_low, output int pre_we,
                          output int lat, output int rsp_cnt, output bit ce_seen);
        int i;
        rd = 16'hFFFF; busy = 0; we_low = 0; pre_we = 0; lat = -1; rsp_cnt = 0; ce_seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        i = 0;
        while (!v_ready && i < 1000) begin
            busy++;
            if (!v_ce1_n) ce_seen = 1;
            if (!v_we_n) we_low++;
            if (!v_ce1_n && v_we_n && we_low == 0) pre_we++;
            if (v_rsp) begin
                rsp_cnt++;
                if (lat < 0) begin lat = i; rd = v_rdata; end
            end
            i++;
            @(negedge clk);
        end
        if (v_rsp) begin
            rsp_cnt++;
            if (lat < 0) begin lat = i; rd = v_rdata; end
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [20:0] a;
        logic [15:0] d;
        logic [1:0]  be;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 21'd3,  16'hA5C3, 2'b11, 16'h0000},
        '{1'b0, 21'd3,  16'h0000, 2'b11, 16'hA5C3},  // R7 full word
        '{1'b1, 21'd3,  16'h1177, 2'b01, 16'h0000},  // low lane only
        '{1'b0, 21'd3,  16'h0000, 2'b11, 16'hA577},  // R7 high lane kept
        '{1'b1, 21'd3,  16'hBB00, 2'b10, 16'h0000},  // high lane only
        '{1'b0, 21'd3,  16'h0000, 2'b01, 16'h0077},  // R7 high lane masked
        '{1'b0, 21'd3,  16'h0000, 2'b10, 16'hBB00},  // R7 low lane masked
        '{1'b1, 21'd63, 16'hFFFF, 2'b11, 16'h0000},
        '{1'b0, 21'd63, 16'h0000, 2'b11, 16'hFFFF},
        '{1'b0, 21'd3,  16'h0000, 2'b11, 16'hBB77}
    };

    initial begin : wdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [15:0] rd;
        int busy, we_low, pre_we, lat, rsp_cnt;
        bit ce_seen;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: pins idle while in reset
        check(w_ce1_n && !w_ce2 && w_we_n && w_oe_n && w_lb_n && w_ub_n && w_dq_oe == 0
              && w_ready && !w_rsp, "R10 x16 in reset", {w_ce1_n, w_ce2, w_we_n, w_oe_n, w_ready}, 5'b10111);
        rst = 1'b0;
        @(negedge clk);
        check(b_ce1_n && !b_ce2 && b_we_n && b_oe_n && b_lb_n && b_ub_n && b_dq_oe == 0
              && b_ready && !b_rsp, "R10 x8 after reset", {b_ce1_n, b_ce2, b_we_n, b_oe_n, b_ready}, 5'b10111);

        // Table walk on the 16-bit instance (R4, R7).
        sel = 1'b0;
        for (int k = 0; k < NV; k++) begin
            run_op(VECS[k].wr, VECS[k].a, VECS[k].d, VECS[k].be, rd, busy, we_low, pre_we, lat, rsp_cnt, ce_seen);
            if (!VECS[k].wr)
                check(rd == VECS[k].exp, $sformatf("R7 R4 vector %0d read", k), rd, VECS[k].exp);
        end

        // Write timing (R1, R2, R3, R6).
        run_op(1'b1, 21'd10, 16'h1234, 2'b11, rd, busy, we_low, pre_we, lat, rsp_cnt, ce_seen);
        check(we_low == EXP_PULSE, "R1 R2 write pulse cycles", we_low, EXP_PULSE);
        check(pre_we == EXP_SETUP, "R1 R2 setup before strobe", pre_we, EXP_SETUP);
        check(busy == EXP_WBUSY, "R3 R6 write busy cycles", busy, EXP_WBUSY);
        check(rsp_cnt == 0, "R6 no response on write", rsp_cnt, 0);

        // Read timing (R4, R5, R6).
        run_op(1'b0, 21'd10, 16'h0000, 2'b11, rd, busy, we_low, pre_we, lat, rsp_cnt, ce_seen);
        check(rd == 16'h1234, "R4 read data", rd, 16'h1234);
        check(lat == EXP_RLAT, "R4 read latency", lat, EXP_RLAT);
        check(busy == EXP_RBUSY, "R5 R6 read busy incl. release", busy, EXP_RBUSY);
        check(rsp_cnt == 1, "R6 single response pulse", rsp_cnt, 1);

        // Zero byte enables (R8).
        run_op(1'b1, 21'd10, 16'hDEAD, 2'b00, rd, busy, we_low, pre_we, lat, rsp_cnt, ce_seen);
        check(!ce_seen && we_low == 0 && busy == 1, "R8 null write no strobe", {ce_seen, busy[3:0]}, 1);
        run_op(1'b0, 21'd10, 16'h0000, 2'b00, rd, busy, we_low, pre_we, lat, rsp_cnt, ce_seen);
        check(!ce_seen && lat == 0 && rd == 16'h0000, "R8 null read returns zero", rd, 0);
        run_op(1'b0, 21'd10, 16'h0000, 2'b11, rd, busy, we_low, pre_we, lat, rsp_cnt, ce_seen);
        check(rd == 16'h1234, "R8 memory untouched", rd, 16'h1234);

        // 8-bit instance (R9).
        sel = 1'b1;
        run_op(1'b1, 21'd5, 16'hFF5A, 2'b01, rd, busy, we_low, pre_we, lat, rsp_cnt, ce_seen);
        check(b_addr == 20'd2, "R9 byte address shift", b_addr, 2);
        run_op(1'b1, 21'd4, 16'h77C3, 2'b01, rd, busy, we_low, pre_we, lat, rsp_cnt, ce_seen);
        run_op(1'b0, 21'd5, 16'h0000, 2'b01, rd, busy, we_low, pre_we, lat, rsp_cnt, ce_seen);
        check(rd == 16'h005A, "R9 odd byte read", rd, 16'h005A);
        run_op(1'b0, 21'd4, 16'h0000, 2'b01, rd, busy, we_low, pre_we, lat, rsp_cnt, ce_seen);
        check(rd == 16'h00C3, "R9 even byte read", rd, 16'h00C3);
        run_op(1'b1, 21'd4, 16'h0011, 2'b10, rd, busy, we_low, pre_we, lat, rsp_cnt, ce_seen);
        check(!ce_seen, "R9 x8 high enable alone is null", ce_seen, 0);
        run_op(1'b0, 21'd4, 16'h0000, 2'b11, rd, busy, we_low, pre_we, lat, rsp_cnt, ce_seen);
        check(rd == 16'h00C3, "R9 x8 byte unchanged", rd, 16'h00C3);

        // Continuous monitors.
        check(fight_cnt == 0, "R5 bus contention", fight_cnt, 0);
        check(addr_move_cnt == 0, "R2 address held in pulse", addr_move_cnt, 0);
        check(x8_pin_cnt == 0, "R9 lane selects and pin 15", x8_pin_cnt, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule